// File: doc/BRIEF.md
# System Clock Prescaler

This block turns one fast PLL clock into a slower core clock and bus clock, both divided by a single programmable divisor. The divisor may be 1, which passes the PLL clock straight through, or any even value from 2 up to a ceiling of 30. A write strobe loads a new divisor. Values outside that set are discarded. An accepted value is not used at once. It is held pending and takes over only at the start of the next output period, so the outputs never show a shortened pulse.

A power-mode input parks both clocks HIGH in the two deep power-down modes. In standby and in normal running they keep toggling. The bus clock fans out to five branches, each with its own enable that is sampled only while the bus clock is low. A status output warns when the programmed divisor would push the system clock below half the crystal frequency, which is the minimum the serial ports need. For simulation, the PLL and crystal rates are parameters given in kHz.

Top module: `sysclk_prescaler`

## Requirements
- R1: A write (`div_wr` high at a rising PLL edge) with `div_in` equal to 1 or to an even value from 2 to 30 is accepted. Once in use, the value appears on `div_applied`.
- R2: A write with `div_in` equal to 0, to an odd value above 1, or to a value above 30 is ignored, and the divisor in use does not change.
- R3: With an even divisor d, one output period lasts d PLL cycles. The first d/2 of those cycles are HIGH and the rest are LOW. `bus_clk` is identical to `core_clk`.
- R4: With divisor 1, `core_clk` follows `clk_pll`.
- R5: `period_start` is high during the last PLL cycle of each output period. `div_applied` changes only at the edge that ends such a cycle, so a write made mid-period leaves the current period at its old length.
- R6: The `pwr_mode` encoding is 0 run, 1 standby, 2 sleep and 3 stop. In sleep and stop, both clocks go HIGH at the next period boundary and stay HIGH. In run and standby they keep toggling.
- R7: Bit i of `branch_en` gates `branch_clk[i]`, in the order 0 DMA controller, 1 memory controller, 2 Ethernet MAC, 3 USB, 4 LCD controller. A branch is LOW whenever the bus clock is LOW. A change to an enable takes effect only during a LOW phase of the bus clock.
- R8: `uart_low` is 1 when 2·PLL_KHZ < XTAL_KHZ·d, where d is the last accepted divisor. It updates in the cycle after the write. With the default rates (100000 kHz and 14746 kHz), this means d ≥ 14.
- R9: After reset, the divisor is 30, every branch is enabled, both clocks are HIGH and, with the default rates, `uart_low` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pll | input | 1 | Fast PLL clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_wr | input | 1 | Divisor write strobe |
| div_in | input | 5 | Requested divisor |
| pwr_mode | input | 2 | Power mode: 0 run, 1 standby, 2 sleep, 3 stop |
| branch_en | input | 5 | Per-branch enables |
| core_clk | output | 1 | Divided core clock |
| bus_clk | output | 1 | Divided bus clock |
| branch_clk | output | 5 | Gated bus clock per branch |
| div_applied | output | 5 | Divisor currently in use |
| period_start | output | 1 | High in the last PLL cycle of each output period |
| uart_low | output | 1 | Programmed divisor starves the serial ports |

## Verification
The results of a write arrive at different times:
- `uart_low` changes one PLL edge after the write.
- A new divisor reaches `div_applied` and the clocks only at the first period boundary after the write, which can be up to 30 cycles later.

The bench therefore waits for two `period_start` cycles before it compares `div_applied`, and before it hands an expected period length to the monitor. The monitor aligns each measurement to a boundary of its own. Parking also waits for a boundary. A gate change is judged in the next LOW phase, and a change made during a HIGH phase is checked to have had no effect. Every output is sampled one nanosecond after a falling PLL edge, or mid-high when the divide-by-1 path is checked.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;

  typedef enum logic [1:0] {
    PM_RUN     = 2'd0,
    PM_STANDBY = 2'd1,
    PM_SLEEP   = 2'd2,
    PM_STOP    = 2'd3
  } pwr_mode_e;

  // divisor set: 1, or even 2..max_div
  function automatic logic div_legal(input int unsigned d, input int unsigned max_div);
    return (d == 1) || ((d >= 2) && (d <= max_div) && ((d % 2) == 0));
  endfunction

  // system clock pll/d below half the crystal rate
  function automatic logic uart_starved(input int unsigned pll_khz,
                                        input int unsigned xtal_khz,
                                        input int unsigned d);
    return (2 * pll_khz) < (xtal_khz * d);
  endfunction

  function automatic logic mode_parks(input logic [1:0] m);
    return (m == PM_SLEEP) || (m == PM_STOP);
  endfunction

endpackage

// File: rtl/sysclk_cfg.sv
`timescale 1ns/1ps
module sysclk_cfg import sysclk_pkg::*; #(
  parameter int MAX_DIV  = 30,
  parameter int PLL_KHZ  = 100000,
  parameter int XTAL_KHZ = 14746,
  parameter int DW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] pend,
  output logic          starve
);
  logic wr_ok;

  assign wr_ok = wr && div_legal(32'(din), MAX_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend <= DW'(MAX_DIV);
    else if (wr_ok) pend <= din;
  end

  assign starve = uart_starved(PLL_KHZ, XTAL_KHZ, 32'(pend));
endmodule

// File: rtl/sysclk_phase.sv
`timescale 1ns/1ps
module sysclk_phase #(
  parameter int MAX_DIV = 30,
  parameter int DW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] pend,
  input  logic          park_req,
  output logic [DW-1:0] act_div,
  output logic          wrap,
  output logic          parked,
  output logic          clk_out
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] cnt;
  logic [DW-1:0] half;
  logic          ph;
  logic          bypass;

  assign half   = act_div >> 1;
  assign bypass = (act_div == ONE);
  assign wrap   = bypass || (cnt == act_div - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      ph      <= 1'b1;
      act_div <= DW'(MAX_DIV);
      parked  <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      ph      <= 1'b1;
      act_div <= pend;
      parked  <= park_req;
    end else begin
      cnt <= cnt + ONE;
      ph  <= (cnt + ONE) < half;
    end
  end

  assign clk_out = parked | (bypass ? clk : ph);
endmodule

// File: rtl/sysclk_gate.sv
`timescale 1ns/1ps
module sysclk_gate (
  input  logic rst_n,
  input  logic clk_in,
  input  logic en,
  output logic gclk
);
  logic en_q;

  // enable is transparent only in the low phase of the source clock
  always_latch begin
    if (!rst_n)       en_q <= 1'b1;
    else if (!clk_in) en_q <= en;
  end

  assign gclk = clk_in & en_q;
endmodule

// File: rtl/sysclk_prescaler.sv
`timescale 1ns/1ps
module sysclk_prescaler import sysclk_pkg::*; #(
  parameter int MAX_DIV  = 30,
  parameter int NBR      = 5,
  parameter int PLL_KHZ  = 100000,
  parameter int XTAL_KHZ = 14746,
  localparam int DW      = $clog2(MAX_DIV + 1)
) (
  input  logic           clk_pll,
  input  logic           rst_n,
  input  logic           div_wr,
  input  logic [DW-1:0]  div_in,
  input  logic [1:0]     pwr_mode,
  input  logic [NBR-1:0] branch_en,
  output logic           core_clk,
  output logic           bus_clk,
  output logic [NBR-1:0] branch_clk,
  output logic [DW-1:0]  div_applied,
  output logic           period_start,
  output logic           uart_low
);
  logic [DW-1:0] pend_div;
  logic          park_req;
  logic          parked;
  logic          div_clk;

  assign park_req = mode_parks(pwr_mode);

  sysclk_cfg #(
    .MAX_DIV (MAX_DIV),
    .PLL_KHZ (PLL_KHZ),
    .XTAL_KHZ(XTAL_KHZ),
    .DW      (DW)
  ) u_cfg (
    .clk   (clk_pll),
    .rst_n (rst_n),
    .wr    (div_wr),
    .din   (div_in),
    .pend  (pend_div),
    .starve(uart_low)
  );

  sysclk_phase #(
    .MAX_DIV(MAX_DIV),
    .DW     (DW)
  ) u_phase (
    .clk     (clk_pll),
    .rst_n   (rst_n),
    .pend    (pend_div),
    .park_req(park_req),
    .act_div (div_applied),
    .wrap    (period_start),
    .parked  (parked),
    .clk_out (div_clk)
  );

  assign core_clk = div_clk;
  assign bus_clk  = div_clk;

  for (genvar i = 0; i < NBR; i++) begin : g_branch
    sysclk_gate u_gate (
      .rst_n (rst_n),
      .clk_in(div_clk),
      .en    (branch_en[i]),
      .gclk  (branch_clk[i])
    );
  end
endmodule

// File: rtl/sysclk_chk.sv
`timescale 1ns/1ps
module sysclk_chk import sysclk_pkg::*; #(
  parameter int MAX_DIV = 30,
  parameter int NBR     = 5,
  parameter int DW      = 5
) (
  input logic           clk_pll,
  input logic           rst_n,
  input logic           core_clk,
  input logic           bus_clk,
  input logic [NBR-1:0] branch_clk,
  input logic [DW-1:0]  div_applied,
  input logic           period_start,
  input logic           parked
);
  // R1
  legal_div_chk: assert property (@(posedge clk_pll) disable iff (!rst_n)
    div_legal(32'(div_applied), MAX_DIV));

  // R5
  boundary_only_chk: assert property (@(posedge clk_pll) disable iff (!rst_n)
    (div_applied != $past(div_applied)) |-> $past(period_start));

  // R6
  park_high_chk: assert property (@(posedge clk_pll) disable iff (!rst_n)
    parked |-> (core_clk && bus_clk));

  // R7
  branch_low_chk: assert property (@(posedge clk_pll) disable iff (!rst_n)
    !bus_clk |-> (branch_clk == '0));
endmodule

bind sysclk_prescaler sysclk_chk #(
  .MAX_DIV(MAX_DIV),
  .NBR    (NBR),
  .DW     (DW)
) u_chk (
  .clk_pll     (clk_pll),
  .rst_n       (rst_n),
  .core_clk    (core_clk),
  .bus_clk     (bus_clk),
  .branch_clk  (branch_clk),
  .div_applied (div_applied),
  .period_start(period_start),
  .parked      (parked)
);

// File: tb/sysclk_prescaler_test.sv
`timescale 1ns/1ps
module sysclk_prescaler_test;
  localparam int DW = 5;
  localparam int NB = 5;

  logic          clk_pll = 1'b0;
  logic          rst_n = 1'b0;
  logic          div_wr = 1'b0;
  logic [DW-1:0] div_in = '0;
  logic [1:0]    pwr_mode = 2'd0;
  logic [NB-1:0] branch_en = '1;
  logic          core_clk, bus_clk, period_start, uart_low;
  logic [NB-1:0] branch_clk;
  logic [DW-1:0] div_applied;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int exp_q[$];

  always #10 clk_pll = ~clk_pll;

  sysclk_prescaler uut (
    .clk_pll(clk_pll), .rst_n(rst_n), .div_wr(div_wr), .div_in(div_in),
    .pwr_mode(pwr_mode), .branch_en(branch_en), .core_clk(core_clk),
    .bus_clk(bus_clk), .branch_clk(branch_clk), .div_applied(div_applied),
    .period_start(period_start), .uart_low(uart_low)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_pll); #1;
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      do cyc(); while (!period_start);
    end
  endtask

  task automatic write_div(input int v);
    @(negedge clk_pll);
    div_wr = 1'b1;
    div_in = DW'(v);
    @(negedge clk_pll);
    div_wr = 1'b0;
    #1;
  endtask

  // driver side of the scoreboard: expect one period of length d
  task automatic expect_period(input int d);
    exp_q.push_back(d);
    wait (exp_q.size() == 0);
  endtask

  task automatic park_check(input string tag);
    int bad;
    bad = 0;
    wait_ticks(2);
    for (int k = 0; k < 20; k++) begin
      cyc();
      if (!(core_clk && bus_clk)) bad++;
    end
    chk(bad == 0, "R6", tag, bad, 0);
  endtask

  // monitor: align to a boundary, measure the next period, compare
  initial begin
    forever begin
      int e, n, hi, mism;
      wait (exp_q.size() > 0);
      e = exp_q[0];
      do cyc(); while (!period_start);
      n = 0; hi = 0; mism = 0;
      do begin
        cyc();
        n++;
        if (core_clk) hi++;
        if (core_clk != bus_clk) mism++;
      end while (!period_start);
      chk(n == e, "R3", "period length", n, e);
      chk(hi == ((e == 1) ? 0 : e / 2), "R3", "high cycles", hi, (e == 1) ? 0 : e / 2);
      chk(mism == 0, "R3", "bus_clk vs core_clk mismatches", mism, 0);
      void'(exp_q.pop_front());
    end
  end

  initial begin
    #3ms;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk_pll);
    rst_n = 1'b1;
    cyc();
    // R9 reset state
    chk(div_applied == 30, "R9", "reset divisor", div_applied, 30);
    chk(core_clk && bus_clk, "R9", "clocks high after reset", core_clk, 1);
    chk(branch_clk == 5'h1F, "R9", "all branches on", branch_clk, 5'h1F);
    chk(uart_low == 1'b1, "R9", "uart flag at 30", uart_low, 1);
    expect_period(30);

    // R1 legal divisors
    write_div(2);
    wait_ticks(2);
    chk(div_applied == 2, "R1", "divisor 2 applied", div_applied, 2);
    expect_period(2);
    write_div(4);
    wait_ticks(2);
    chk(div_applied == 4, "R1", "divisor 4 applied", div_applied, 4);
    expect_period(4);

    // R2 rejected values
    write_div(3);
    write_div(31);
    write_div(0);
    wait_ticks(3);
    chk(div_applied == 4, "R2", "illegal writes ignored", div_applied, 4);
    expect_period(4);

    // R8 uart threshold
    write_div(12);
    chk(uart_low == 1'b0, "R8", "flag at 12", uart_low, 0);
    wait_ticks(2);
    expect_period(12);
    write_div(14);
    chk(uart_low == 1'b1, "R8", "flag at 14", uart_low, 1);
    wait_ticks(2);
    expect_period(14);

    write_div(4);
    wait_ticks(2);
    // R5 mid-period write keeps the current period
    wait_ticks(1);
    cyc();
    div_wr = 1'b1;
    div_in = DW'(6);
    cyc();
    div_wr = 1'b0;
    bad = 0;
    while (!period_start) begin
      if (div_applied != 4) bad++;
      cyc();
    end
    chk(bad == 0 && div_applied == 4, "R5", "old divisor held to boundary", div_applied, 4);
    cyc();
    chk(div_applied == 6, "R5", "new divisor after boundary", div_applied, 6);
    expect_period(6);

    // R4 pass-through
    write_div(1);
    wait_ticks(2);
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk_pll); #5;
      if (core_clk !== 1'b1) bad++;
      cyc();
      if (core_clk !== 1'b0) bad++;
    end
    chk(bad == 0, "R4", "core follows pll", bad, 0);
    expect_period(1);

    // R6 power modes at divisor 4
    write_div(4);
    wait_ticks(2);
    pwr_mode = 2'd2;
    park_check("sleep parks high");
    pwr_mode = 2'd1;
    wait_ticks(2);
    expect_period(4);
    pwr_mode = 2'd3;
    park_check("stop parks high");
    pwr_mode = 2'd0;
    wait_ticks(2);
    expect_period(4);

    // R7 branch gates
    branch_en = 5'b11011;
    wait_ticks(2);
    cyc();
    chk(branch_clk == 5'b11011, "R7", "gated high phase", branch_clk, 5'b11011);
    cyc(); cyc();
    chk(branch_clk == 5'b00000, "R7", "branches low in low phase", branch_clk, 0);
    wait_ticks(1);
    cyc();
    branch_en = 5'b00000;
    #1;
    chk(branch_clk == 5'b11011, "R7", "enable change in high phase held", branch_clk, 5'b11011);
    cyc();
    chk(branch_clk == 5'b11011, "R7", "still held second high cycle", branch_clk, 5'b11011);
    wait_ticks(1);
    cyc();
    chk(branch_clk == 5'b00000, "R7", "all off next high phase", branch_clk, 0);
    branch_en = 5'h1F;
    wait_ticks(1);
    cyc();
    chk(branch_clk == 5'h1F, "R7", "all back on", branch_clk, 5'h1F);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule